// File: doc/BRIEF.md
# Parallel Half-Precision Max-Pooling Unit

This block reduces a pooling window to its largest element on eight channels at once. Every input word is 128 bits wide and packs eight 16-bit half-precision values, one per channel lane. Words are written into a small input queue. The queue only shows a newly written word as available after a fixed write latency. The unit takes one word at a time from the queue and hands each lane's value to a two-cycle comparator. Each lane keeps its own running maximum. The next word is taken only after the current comparison has been committed.

The comparison is done on the raw bit patterns, with no floating-point core. Every lane's running maximum starts at positive zero. After `kernel_size` elements have been folded in, the eight maxima are copied into the result register and a one-cycle ready pulse is raised. The next window then starts by itself, with fresh maxima, if the queue still holds words. Pooling keeps the channel count: one result word carries the same eight lanes as the input words. Walking the window over the feature surface and addressing memory are left to the surrounding logic.

Top module: `maxpool_unit`

## Requirements
- R1: The eight lanes work independently. Lane i occupies bits [16i+15:16i] of `wr_data` and of `res_data`, and each result lane depends only on the same lane of the input words.
- R2: A candidate x replaces the stored maximum m only when x is strictly larger than m. The order is decided as follows:
  - When the sign bits (bit 15) differ, the value with sign 0 is larger.
  - When both signs are 0, the larger 15-bit magnitude is larger.
  - When both signs are 1, the smaller 15-bit magnitude is larger.
  - +0 and -0 compare equal.
  - A NaN (exponent bits 14:10 all ones and a non-zero fraction in bits 9:0) on either side is never larger.
- R3: Every lane's running maximum is 0x0000 at the start of each window. A window that holds only negative values, -0 or NaN therefore yields 0x0000.
- R4: When the `kernel_size`-th element of a window is committed, `res_data` is loaded with the eight maxima and `res_ready` is high for exactly one cycle. A `kernel_size` of 0 behaves like 1.
- R5: A word written at clock edge W into an idle, empty unit is visible in the queue after edge W+6. It is fetched in the following cycle. With `kernel_size` = 1, `res_ready` is high after edge W+9. `res_ready` always rises exactly three cycles after the fetch that completes the window.
- R6: A fetch starts a two-cycle comparison, and the next fetch can happen no earlier than the third cycle after it. With words waiting and `kernel_size` = 1, successive `res_ready` pulses are three cycles apart.
- R7: After a window completes, the next window starts automatically with the maxima reset. Its result does not depend on earlier windows.
- R8: While `en` is low, no word is fetched and `res_ready` stays low. Deasserting `en` discards the partial window: the element count and the maxima are cleared.
- R9: `in_full` is high while the queue holds DEPTH (default 8) words. Writes are accepted while it is low.
- R10: After reset, `res_data` is zero and `res_ready` and `in_full` are low. `res_data` changes only in the cycle in which `res_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Unit enable. Low clears the window state and stops fetching |
| kernel_size | input | KW (8) | Number of elements per pooling window |
| wr_en | input | 1 | Write strobe into the input queue |
| wr_data | input | LANES*16 (128) | Eight packed half-precision elements |
| in_full | output | 1 | Input queue holds DEPTH words |
| res_data | output | LANES*16 (128) | Eight packed window maxima |
| res_ready | output | 1 | One-cycle pulse: `res_data` holds a new result |

## Verification
A lane whose maximum was not cleared between windows shows at the ports as a result that is too large. This appears on the very next `res_ready` pulse. It is exposed by feeding a window of small values after a window of large values, and by a window made only of negative numbers. A wrong element count or a lost clear after `en` drops shifts the window boundary, so the next result contains a stale element. A comparator that commits early, or a queue that shows words too soon, moves `res_ready` off its fixed 9-cycle or 3-cycle distance. The bench times this to the exact edge.

// File: rtl/maxpool_pkg.sv
package maxpool_pkg;

  localparam int HP_W = 16;

  typedef enum logic [1:0] {
    MP_FETCH  = 2'd0,
    MP_EVAL   = 2'd1,
    MP_COMMIT = 2'd2
  } mp_state_e;

  function automatic logic hp_is_nan(input logic [HP_W-1:0] v);
    return (v[14:10] == 5'h1f) && (v[9:0] != 10'h000);
  endfunction

  // True when cand is strictly larger than ref_v in half-precision order.
  function automatic logic hp_gt(input logic [HP_W-1:0] cand,
                                 input logic [HP_W-1:0] ref_v);
    logic both_zero;
    both_zero = (cand[14:0] == 15'h0) && (ref_v[14:0] == 15'h0);
    if (hp_is_nan(cand) || hp_is_nan(ref_v) || both_zero)
      return 1'b0;
    else if (cand[15] != ref_v[15])
      return !cand[15];
    else if (!cand[15])
      return cand[14:0] > ref_v[14:0];
    else
      return cand[14:0] < ref_v[14:0];
  endfunction

endpackage

// File: rtl/mp_lat_fifo.sv
module mp_lat_fifo #(
  parameter int W     = 128,
  parameter int DEPTH = 8,
  parameter int LAT   = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   occ;
  logic [AW:0]   vis;
  logic          wr_fire, rd_fire, mature;

  assign full    = (occ == (AW+1)'(DEPTH));
  assign empty   = (vis == '0);
  assign wr_fire = wr_en && !full;
  assign rd_fire = rd_en && !empty;
  assign rd_data = mem[rptr];

  // write-visibility delay line
  generate
    if (LAT > 1) begin : g_pipe
      logic [LAT-1:0] pipe;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[LAT-2:0], wr_fire};
      end
      assign mature = pipe[LAT-1];
    end else begin : g_single
      logic pipe1;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe1 <= 1'b0;
        else        pipe1 <= wr_fire;
      end
      assign mature = pipe1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      occ  <= '0;
      vis  <= '0;
    end else begin
      if (wr_fire) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (rd_fire) rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      case ({wr_fire, rd_fire})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
      case ({mature, rd_fire})
        2'b10:   vis <= vis + 1'b1;
        2'b01:   vis <= vis - 1'b1;
        default: vis <= vis;
      endcase
    end
  end

endmodule

// File: rtl/mp_lane.sv
module mp_lane
  import maxpool_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            load,
  input  logic [HP_W-1:0] din,
  input  logic            eval,
  input  logic            commit,
  output logic [HP_W-1:0] max_next
);
  logic [HP_W-1:0] op_q, max_q;
  logic            gt_q;

  assign max_next = gt_q ? op_q : max_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= '0;
      gt_q  <= 1'b0;
      max_q <= '0;
    end else begin
      if (load) op_q <= din;
      if (eval) gt_q <= hp_gt(op_q, max_q);
      if (clr)         max_q <= '0;
      else if (commit) max_q <= max_next;
    end
  end

endmodule

// File: rtl/maxpool_unit.sv
module maxpool_unit
  import maxpool_pkg::*;
#(
  parameter int LANES    = 8,
  parameter int DEPTH    = 8,
  parameter int FIFO_LAT = 6,
  parameter int KW       = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic [KW-1:0]         kernel_size,
  input  logic                  wr_en,
  input  logic [LANES*HP_W-1:0] wr_data,
  output logic                  in_full,
  output logic [LANES*HP_W-1:0] res_data,
  output logic                  res_ready
);
  localparam int DW = LANES * HP_W;

  mp_state_e     state_q;
  logic [KW-1:0] elem_cnt;
  logic [DW-1:0] head_word, max_word;
  logic          fifo_empty, fifo_pop;
  logic          lane_eval, lane_commit, lane_clr, win_last;
  logic [DW-1:0] res_q;
  logic          ready_q;

  mp_lat_fifo #(.W(DW), .DEPTH(DEPTH), .LAT(FIFO_LAT)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (fifo_pop),
    .rd_data (head_word),
    .empty   (fifo_empty),
    .full    (in_full)
  );

  assign fifo_pop    = en && (state_q == MP_FETCH) && !fifo_empty;
  assign lane_eval   = en && (state_q == MP_EVAL);
  assign lane_commit = en && (state_q == MP_COMMIT);
  assign win_last    = lane_commit &&
                       (({1'b0, elem_cnt} + 1'b1) >= {1'b0, kernel_size});
  assign lane_clr    = !en || win_last;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      mp_lane u_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (lane_clr),
        .load     (fifo_pop),
        .din      (head_word[g*HP_W +: HP_W]),
        .eval     (lane_eval),
        .commit   (lane_commit),
        .max_next (max_word[g*HP_W +: HP_W])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MP_FETCH;
    end else if (!en) begin
      state_q <= MP_FETCH;
    end else begin
      case (state_q)
        MP_FETCH:  if (fifo_pop) state_q <= MP_EVAL;
        MP_EVAL:   state_q <= MP_COMMIT;
        default:   state_q <= MP_FETCH;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 elem_cnt <= '0;
    else if (!en || win_last)   elem_cnt <= '0;
    else if (lane_commit)       elem_cnt <= elem_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      ready_q <= win_last;
      if (win_last) res_q <= max_word;
    end
  end

  assign res_data  = res_q;
  assign res_ready = ready_q;

endmodule

// File: rtl/maxpool_unit_chk.sv
module maxpool_unit_chk #(
  parameter int W = 128
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         fifo_pop,
  input logic         res_ready,
  input logic [W-1:0] res_data
);

  // R4
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_ready |=> !res_ready);

  // R6
  pop_gap1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |=> !fifo_pop);

  // R6
  pop_gap2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fifo_pop) |=> !fifo_pop);

  // R5
  fetch_to_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_ready |-> $past(fifo_pop, 3));

  // R8
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !res_ready);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_ready |-> $stable(res_data));

endmodule

bind maxpool_unit maxpool_unit_chk #(.W(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .fifo_pop  (fifo_pop),
  .res_ready (res_ready),
  .res_data  (res_data)
);

// File: tb/maxpool_unit_bench.sv
module maxpool_unit_bench;
  localparam int LANES = 8;
  localparam int DEPTH = 8;
  localparam int DW    = LANES * 16;
  localparam int NVEC  = 16;

  // {first element, second element, expected max} per lane, kernel 2
  localparam logic [47:0] VEC [NVEC] = '{
    {16'h3C00, 16'h4000, 16'h4000}, {16'h4000, 16'h3C00, 16'h4000},
    {16'hBC00, 16'hC000, 16'h0000}, {16'h8000, 16'h0000, 16'h0000},
    {16'h0000, 16'h8000, 16'h0000}, {16'h3C00, 16'hBC00, 16'h3C00},
    {16'h7C00, 16'h7BFF, 16'h7C00}, {16'h7E00, 16'h3C00, 16'h3C00},
    {16'h0001, 16'h0000, 16'h0001}, {16'h8001, 16'h0001, 16'h0001},
    {16'h3555, 16'h3556, 16'h3556}, {16'hFC00, 16'h0400, 16'h0400},
    {16'h7E00, 16'h7E01, 16'h0000}, {16'h4400, 16'h4400, 16'h4400},
    {16'hC400, 16'h3800, 16'h3800}, {16'h0200, 16'h0100, 16'h0200}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [7:0]    kernel_size = 8'd1;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          in_full;
  logic [DW-1:0] res_data;
  logic          res_ready;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  maxpool_unit u_maxpool_unit (
    .clk(clk), .rst_n(rst_n), .en(en), .kernel_size(kernel_size),
    .wr_en(wr_en), .wr_data(wr_data), .in_full(in_full),
    .res_data(res_data), .res_ready(res_ready)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      $display("FAIL watchdog: actual cycles=%0d expected completion", cyc);
      fails  = fails + 1;
      checks = checks + 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // Independent ordering model: signed integer key, NaN never wins.
  function automatic bit bm_larger(input logic [15:0] a, input logic [15:0] b);
    int ka, kb;
    if ((a[14:10] == 5'h1f && a[9:0] != 0) || (b[14:10] == 5'h1f && b[9:0] != 0))
      return 1'b0;
    ka = a[15] ? -int'(a[14:0]) : int'(a[14:0]);
    kb = b[15] ? -int'(b[14:0]) : int'(b[14:0]);
    return ka > kb;
  endfunction

  function automatic logic [DW-1:0] fold(input logic [DW-1:0] acc, input logic [DW-1:0] w);
    logic [DW-1:0] r;
    for (int l = 0; l < LANES; l++)
      r[l*16 +: 16] = bm_larger(w[l*16 +: 16], acc[l*16 +: 16]) ? w[l*16 +: 16] : acc[l*16 +: 16];
    return r;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push(input logic [DW-1:0] w);
    while (in_full) tick();
    wr_en   = 1'b1;
    wr_data = w;
    tick();
    wr_en   = 1'b0;
  endtask

  // counts edges until res_ready is seen (0 = not seen)
  task automatic wait_ready(input int lim, output int n);
    n = 0;
    for (int i = 1; i <= lim; i++) begin
      tick();
      if (res_ready) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic idle_no_ready(input int cycles, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      tick();
      if (res_ready) seen = 1'b1;
    end
  endtask

  initial begin
    logic [DW-1:0] w0, w1, expv, acc;
    logic [DW-1:0] words [4];
    int  n;
    bit  seen;

    repeat (3) @(negedge clk);
    // R10 reset state
    check(res_data == '0, "R10 reset res_data", res_data, '0);
    check(res_ready == 1'b0, "R10 reset res_ready", DW'(res_ready), '0);
    check(in_full == 1'b0, "R10 reset in_full", DW'(in_full), '0);
    rst_n = 1'b1;
    tick();

    // R5 latency, kernel 1
    en = 1'b1;
    kernel_size = 8'd1;
    w0 = {16'h4248, 16'hBC00, 16'h0001, 16'h7C00, 16'h8000, 16'h3C00, 16'hFBFF, 16'h5000};
    push(w0);
    wait_ready(40, n);
    check(n == 9, "R5 write-to-ready edges", DW'(n), DW'(9));
    check(res_data == fold('0, w0), "R1 R2 single element result", res_data, fold('0, w0));
    tick();
    // R4 pulse width
    check(res_ready == 1'b0, "R4 ready one cycle", DW'(res_ready), '0);

    // Table walk, kernel 2: R1 R2 R3
    kernel_size = 8'd2;
    for (int g = 0; g < NVEC / LANES; g++) begin
      w0 = '0; w1 = '0; expv = '0;
      for (int l = 0; l < LANES; l++) begin
        w0[l*16 +: 16]   = VEC[g*LANES + l][47:32];
        w1[l*16 +: 16]   = VEC[g*LANES + l][31:16];
        expv[l*16 +: 16] = VEC[g*LANES + l][15:0];
      end
      push(w0);
      push(w1);
      wait_ready(60, n);
      check(n != 0 && res_data == expv, "R2 R3 table group", res_data, expv);
    end

    // R8 disabled: data waits, no ready; then R6 R7 back-to-back windows
    en = 1'b0;
    kernel_size = 8'd1;
    words[0] = {8{16'h4000}};
    words[1] = {8{16'h3C00}};
    words[2] = {16'hC000, 16'h0000, 16'h8000, 16'h3800, 16'h7E00, 16'h0400, 16'hBC00, 16'h2000};
    words[3] = {8{16'h8001}};
    for (int i = 0; i < 4; i++) push(words[i]);
    idle_no_ready(20, seen);
    check(!seen, "R8 no ready while disabled", DW'(seen), '0);
    en = 1'b1;
    for (int i = 0; i < 4; i++) begin
      wait_ready(20, n);
      check(n == 3, "R6 ready spacing", DW'(n), DW'(3));
      check(res_data == fold('0, words[i]), "R7 window restart result",
            res_data, fold('0, words[i]));
    end

    // R8 partial window discarded on enable drop
    kernel_size = 8'd2;
    push({8{16'h7800}});
    idle_no_ready(14, seen);
    check(!seen, "R4 no ready before window complete", DW'(seen), '0);
    en = 1'b0;
    tick();
    tick();
    en = 1'b1;
    push({8{16'h3000}});
    push({8{16'h3400}});
    wait_ready(60, n);
    check(n != 0 && res_data == {8{16'h3400}}, "R8 partial window cleared",
          res_data, {8{16'h3400}});

    // R9 full flag and a kernel-8 window
    en = 1'b0;
    kernel_size = 8'd8;
    acc = '0;
    for (int i = 0; i < DEPTH; i++) begin
      w0 = '0;
      for (int l = 0; l < LANES; l++)
        w0[l*16 +: 16] = 16'((l * 7 + i * 3) % 11) << 10 | ((i % 2 == 0) ? 16'h8000 : 16'h0000);
      acc = fold(acc, w0);
      push(w0);
    end
    check(in_full == 1'b1, "R9 full after DEPTH words", DW'(in_full), DW'(1));
    en = 1'b1;
    wait_ready(80, n);
    check(n != 0 && res_data == acc, "R4 kernel 8 result", res_data, acc);
    check(in_full == 1'b0, "R9 not full after drain", DW'(in_full), '0);

    // R4 kernel_size 0 acts as 1
    kernel_size = 8'd0;
    w0 = {8{16'h1234}};
    push(w0);
    wait_ready(40, n);
    check(n == 9 && res_data == w0, "R4 kernel zero as one", res_data, w0);

    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule